// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block waits, on the host side, for a flash device to finish an embedded program or erase operation. Once the command sequence has gone out, the block is started with the target address. It then runs status reads over a simple parallel read/write port. Each read is one request that a done pulse ends. The reads come in pairs, issued back to back. The block compares status bit 6 between the two reads of a pair. If the bit is still flipping, the device is busy. If it holds its value, the operation has ended.

Bit 5 of the second read flags an exceeded time limit, but the block does not trust it on its own. It first re-polls one more pair. Only if bit 6 is still flipping after that does it treat the operation as failed. On a failure it writes the reset command, and it reports the failure only after that write has finished. A parameter caps the number of busy pairs. When the cap is reached, the block reports a watchdog result. An optional sector-status mode reads one pair and uses bit 2 and bit 6 together. Bit 2 flipping means the addressed sector is selected for erase. Bit 6 flipping means the erase is active, and bit 6 steady means it is suspended.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A one-cycle `start_i` in idle latches `addr_i` and `sector_mode_i`, and every access of that run uses the latched address. A `start_i` raised while a run is in progress has no effect.
- R2: A request (`bus_rd_o` or `bus_wr_o`) stays high until the cycle in which `bus_done_i` is high, and each done pulse ends exactly one access. The two reads of a pair are issued back to back, and the two request kinds are never high together.
- R3: In completion mode, if bit 6 is the same in both reads of a pair, the run ends with status ok (`status_o` = 2'b01). If bit 6 differs and bit 5 of the second read is 0, another pair is read.
- R4: If bit 6 differs and bit 5 of the second read is 1, one more pair is read as a re-check. If bit 6 is steady in that re-check pair, the run ends with status ok, and no write is issued.
- R5: If bit 6 still differs in the re-check pair, the block issues one write of 0xF0 to the latched address. It then ends with status device-fail (`status_o` = 2'b10), raising `done_o` in the cycle right after the write's done.
- R6: After MAX_POLLS busy pairs with bit 5 clear, the run ends with status watchdog (`status_o` = 2'b11). It issues no further read and no write, so the run has exactly 2*MAX_POLLS reads.
- R7: `done_o` is a one-cycle pulse at the end of every run, with no request active during it. `status_o` changes only together with `done_o` and holds its value between runs. After reset, `status_o` = 2'b00, the sector outputs are 0, and no request is active.
- R8: In sector-status mode, the run reads exactly one pair and ends with status ok, ignoring bit 5. It sets `sect_sel_o` to whether bit 2 differed and `sect_erasing_o` to whether bit 6 differed. A completion-mode run leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (sampled in idle only) |
| sector_mode_i | input | 1 | 1: sector-status mode, 0: completion polling |
| addr_i | input | AW | Address to poll |
| bus_rd_o | output | 1 | Read request |
| bus_wr_o | output | 1 | Write request |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | DW | Write data (reset command during writes) |
| bus_rdata_i | input | DW | Read data, valid with bus_done_i |
| bus_done_i | input | 1 | Ends the current access |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | Sticky result: 00 none, 01 ok, 10 device-fail, 11 watchdog |
| sect_sel_o | output | 1 | Sector selected for erase (sector mode result) |
| sect_erasing_o | output | 1 | Erase active (1) or suspended (0) |

## Verification
The hardest case to reach is the path where bit 5 goes high in the very pair where bit 6 stops flipping. In that case the re-check must clear the run instead of failing it, and the outcome depends on the exact read index at which each bit changes. The bench's device model makes bit 6 flip until a chosen read index and raises bit 5 from another chosen index. Directed runs place these two indices next to each other. Random runs spread them widely, and the done latency is randomized as well.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_RD_A,
    PS_RD_B,
    PS_EVAL,
    PS_RST_WR,
    PS_FINISH
  } poll_state_e;

  typedef enum logic [1:0] {
    RES_NONE     = 2'b00,
    RES_OK       = 2'b01,
    RES_DEV_FAIL = 2'b10,
    RES_WDOG     = 2'b11
  } poll_res_e;
endpackage

// File: rtl/poll_pair_cmp.sv
module poll_pair_cmp #(
  parameter int DW       = 8,
  parameter int TOG_BIT  = 6,
  parameter int AUX_BIT  = 2,
  parameter int ERR_BIT  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          slot_i,
  input  logic [DW-1:0] data_i,
  output logic          tog_o,
  output logic          aux_tog_o,
  output logic          err_o
);
  localparam int NB = 3;

  logic [NB-1:0] first_q, second_q, pick;
  logic unused_rdata;

  assign unused_rdata = ^data_i;
  assign pick = {data_i[ERR_BIT], data_i[AUX_BIT], data_i[TOG_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      second_q <= '0;
    end else if (cap_i) begin
      if (slot_i) second_q <= pick;
      else        first_q  <= pick;
    end
  end

  assign tog_o     = first_q[0] ^ second_q[0];
  assign aux_tog_o = first_q[1] ^ second_q[1];
  assign err_o     = second_q[2];
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import poll_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 8,
  parameter int          MAX_POLLS = 64,
  parameter logic [7:0]  RESET_CMD = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sector_mode_i,
  input  logic [AW-1:0] addr_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_done_i,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic          sect_sel_o,
  output logic          sect_erasing_o
);
  poll_state_e   state_q, state_d;
  poll_res_e     res_q, res_d;
  logic [AW-1:0] addr_q;
  logic          smode_q, recheck_q, recheck_d;
  logic          sel_q, sel_d, ers_q, ers_d;
  logic          cap, tog6, tog2, err5, wd_last, wd_inc, wd_clr;

  assign cap = bus_done_i && (state_q == PS_RD_A || state_q == PS_RD_B);

  poll_pair_cmp #(.DW(DW)) u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .slot_i   (state_q == PS_RD_B),
    .data_i   (bus_rdata_i),
    .tog_o    (tog6),
    .aux_tog_o(tog2),
    .err_o    (err5)
  );

  poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wd_clr),
    .inc_i (wd_inc),
    .last_o(wd_last)
  );

  always_comb begin
    state_d   = state_q;
    res_d     = res_q;
    recheck_d = recheck_q;
    sel_d     = sel_q;
    ers_d     = ers_q;
    wd_inc    = 1'b0;
    wd_clr    = 1'b0;
    unique case (state_q)
      PS_IDLE: if (start_i) begin
        state_d   = PS_RD_A;
        recheck_d = 1'b0;
        wd_clr    = 1'b1;
      end
      PS_RD_A: if (bus_done_i) state_d = PS_RD_B;
      PS_RD_B: if (bus_done_i) state_d = PS_EVAL;
      PS_EVAL: begin
        if (smode_q) begin
          sel_d   = tog2;
          ers_d   = tog6;
          res_d   = RES_OK;
          state_d = PS_FINISH;
        end else if (recheck_q) begin
          if (tog6) state_d = PS_RST_WR;
          else begin
            res_d   = RES_OK;
            state_d = PS_FINISH;
          end
        end else if (!tog6) begin
          res_d   = RES_OK;
          state_d = PS_FINISH;
        end else if (err5) begin
          // time-limit flag may race completion: confirm with one more pair
          recheck_d = 1'b1;
          state_d   = PS_RD_A;
        end else if (wd_last) begin
          res_d   = RES_WDOG;
          state_d = PS_FINISH;
        end else begin
          wd_inc  = 1'b1;
          state_d = PS_RD_A;
        end
      end
      PS_RST_WR: if (bus_done_i) begin
        res_d   = RES_DEV_FAIL;
        state_d = PS_FINISH;
      end
      PS_FINISH: state_d = PS_IDLE;
      default:   state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_IDLE;
      res_q     <= RES_NONE;
      addr_q    <= '0;
      smode_q   <= 1'b0;
      recheck_q <= 1'b0;
      sel_q     <= 1'b0;
      ers_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      res_q     <= res_d;
      recheck_q <= recheck_d;
      sel_q     <= sel_d;
      ers_q     <= ers_d;
      if (state_q == PS_IDLE && start_i) begin
        addr_q  <= addr_i;
        smode_q <= sector_mode_i;
      end
    end
  end

  assign bus_rd_o       = (state_q == PS_RD_A) || (state_q == PS_RD_B);
  assign bus_wr_o       = (state_q == PS_RST_WR);
  assign bus_addr_o     = addr_q;
  assign bus_wdata_o    = bus_wr_o ? DW'(RESET_CMD) : '0;
  assign done_o         = (state_q == PS_FINISH);
  assign status_o       = res_q;
  assign sect_sel_o     = sel_q;
  assign sect_erasing_o = ers_q;
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rd_o,
  input logic       bus_wr_o,
  input logic       bus_done_i,
  input logic       done_o,
  input logic [1:0] status_o
);
  a_r2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  a_r2_hold_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && !bus_done_i |=> bus_rd_o);

  a_r2_hold_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o && !bus_done_i |=> bus_wr_o);

  a_r5_fail_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_wr_o) |-> done_o && status_o == 2'b10);

  a_r7_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(status_o));

  a_r7_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_rd_o && !bus_wr_o);
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_rd_o  (bus_rd_o),
  .bus_wr_o  (bus_wr_o),
  .bus_done_i(bus_done_i),
  .done_o    (done_o),
  .status_o  (status_o)
);

// File: tb/sim_flash_poll_ctrl.sv
`timescale 1ns/1ps
module sim_flash_poll_ctrl;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int MAXP = 8;
  localparam int NO_ERR = -1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, smode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd, wr, done, s_sel, s_ers;
  logic [AW-1:0] baddr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata = '0;
  logic bdone = 1'b0;
  logic [1:0] status;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cur_b = 0, cur_f = NO_ERR, rd_idx = 0, wr_cnt = 0, lat = 0;
  bit cur_sel = 0, in_op = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] last_wdata = '0;
  bit exp_sel = 0, exp_ers = 0;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sector_mode_i(smode),
    .addr_i(addr), .bus_rd_o(rd), .bus_wr_o(wr), .bus_addr_o(baddr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_done_i(bdone),
    .done_o(done), .status_o(status), .sect_sel_o(s_sel), .sect_erasing_o(s_ers));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit dq6(int i, int b);
    return (i < b) ? i[0] : 1'b1;
  endfunction
  function automatic bit dq5(int i, int f);
    return (f >= 0) && (i >= f);
  endfunction
  function automatic logic [7:0] dev_word(int i, int b, int f, bit sel);
    bit d2 = sel ? i[0] : 1'b0;
    return {1'b0, dq6(i, b), dq5(i, f), 2'b00, d2, 2'b01};
  endfunction

  // expected outcome of a completion-mode run
  function automatic void predict(int b, int f, output int reads, output int st);
    int r = 0, it = 0;
    bit rc = 0, t6;
    reads = 0; st = 0;
    forever begin
      t6 = dq6(r, b) != dq6(r + 1, b);
      r += 2;
      if (rc) begin st = t6 ? 2 : 1; break; end
      if (!t6) begin st = 1; break; end
      if (dq5(r - 1, f)) begin rc = 1; continue; end
      if (it == MAXP - 1) begin st = 3; break; end
      it++;
    end
    reads = r;
  endfunction

  // device model and access monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      if (bdone) bdone = 1'b0;
      else if ((rd || wr) && rst_n) begin
        if (!in_op) check(0, "R7 access while idle", 1, 0);
        if (lat == 0) begin
          check(baddr == exp_addr, "R1 access address", int'(baddr), int'(exp_addr));
          if (rd) begin
            rdata = dev_word(rd_idx, cur_b, cur_f, cur_sel);
            rd_idx++;
          end else begin
            last_wdata = wdata;
            wr_cnt++;
          end
          bdone = 1'b1;
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  task automatic run_op(int b, int f, bit sm, bit sel, logic [AW-1:0] a, bit poke, string tag);
    int exp_reads, exp_st, w;
    cur_b = b; cur_f = f; cur_sel = sel; rd_idx = 0; wr_cnt = 0;
    exp_addr = a; in_op = 1;
    @(negedge clk);
    start = 1; smode = sm; addr = a;
    @(negedge clk);
    start = 0; smode = ~sm; addr = ~a;
    if (poke) begin
      @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    in_op = 0;
    if (sm) begin
      exp_reads = 2; exp_st = 1;
      exp_sel = sel; exp_ers = dq6(0, b) != dq6(1, b);
    end else predict(b, f, exp_reads, exp_st);
    check(done == 1'b1, {tag, " done seen"}, int'(done), 1);
    check(status == 2'(exp_st), {tag, " status"}, int'(status), exp_st);
    check(rd_idx == exp_reads, {tag, " read count"}, rd_idx, exp_reads);
    check(wr_cnt == (exp_st == 2 ? 1 : 0), "R5 write count", wr_cnt, exp_st == 2 ? 1 : 0);
    if (exp_st == 2) check(last_wdata == 8'hF0, "R5 reset data", int'(last_wdata), 'hF0);
    check(s_sel == exp_sel && s_ers == exp_ers, "R8 sector outputs",
          int'({s_sel, s_ers}), int'({exp_sel, exp_ers}));
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(status == 2'(exp_st), "R7 status sticky", int'(status), exp_st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 2'b00 && !rd && !wr && !done && !s_sel && !s_ers,
          "R7 reset state", int'({status, rd, wr, done}), 0);
    rst_n = 1;
    @(negedge clk);
    void'($urandom(32'h5eed1));
    run_op(0, NO_ERR, 0, 0, 12'h123, 0, "R3 immediate");
    run_op(7, NO_ERR, 0, 0, 12'h0a5, 1, "R1 ignored start");
    run_op(6, 5, 0, 0, 12'h3c3, 0, "R4 recheck clears");
    run_op(1000, 3, 0, 0, 12'h777, 0, "R5 fail");
    run_op(1000, NO_ERR, 0, 0, 12'h010, 0, "R6 watchdog");
    run_op(2 * MAXP, NO_ERR, 0, 0, 12'h011, 0, "R6 edge");
    run_op(1000, 1, 1, 1, 12'h222, 0, "R8 erasing selected");
    run_op(0, NO_ERR, 1, 0, 12'h333, 0, "R8 suspended unselected");
    run_op(4, NO_ERR, 0, 0, 12'h444, 0, "R8 unchanged by R3 run");
    for (int k = 0; k < 40; k++) begin
      int b = $urandom_range(0, 24);
      int f = ($urandom_range(0, 2) == 0) ? NO_ERR : $urandom_range(0, 30);
      bit sm = ($urandom_range(0, 3) == 0);
      run_op(b, f, sm, 1'($urandom_range(0, 1)), AW'($urandom),
             1'($urandom_range(0, 1)), "R2 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule